// File: doc/BRIEF.md
# Distributed CBR Refresh and Self-Refresh Scheduler

This block keeps a 4K-row dynamic memory alive. It times one CAS-before-RAS refresh per row slot, which is 31.25 µs at the extended 128 ms retention period. The memory's own row counter picks the row, so the block never drives a row address. The block borrows the memory bus from the access controller through a request/grant pair. If the bus is not granted in time, missed slots are counted up to a limit. Once the grant comes, the owed refreshes are issued one after another without giving the bus back.

For low-power standby, a held sleep request makes the block win the bus and start a CAS-before-RAS cycle. Row strobe then stays low for as long as the request is held, and never for less than the minimum self-refresh entry time. When the request is dropped, row strobe rises first and column strobe follows one cycle later. Row strobe then stays high for the exit time, and only after that does the ready output return. Refresh was distributed before sleep, so the backlog is cleared on entry and normal slot timing restarts after wake. No burst refresh is needed.

Clock frequency and every memory timing are parameters given in nanoseconds. They are converted to whole clock cycles and rounded up.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted (rst_n low), both strobes are high (inactive), bus_req is 0 and mem_ready is 1.
- R2: A refresh becomes owed once every SLOT_CYC clock cycles, counted from reset release. With the grant given promptly, one refresh pulse (a falling edge of row_strobe_n) follows each slot.
- R3: Strobe activity happens only while bus_req is 1. Once bus_req is raised, no strobe moves until bus_gnt is seen as 1. bus_gnt has no effect while the block is not waiting for it.
- R4: Each refresh drives col_strobe_n low for LEAD_CYC cycles before row_strobe_n falls. Both stay low for ROW_CYC cycles, then both stay high for PRE_CYC cycles.
- R5: Owed refreshes are counted up to MAX_POSTPONE and saturate there. After the grant they are issued back to back, and bus_req stays 1 until none is owed.
- R6: When a new slot expires in the same cycle that an owed refresh is started, the owed count is unchanged, so one more refresh follows.
- R7: A sleep request seen while the block is idle is accepted and mem_ready falls in the next cycle. After the grant, a CAS-before-RAS entry is made and row_strobe_n stays low for at least ENTRY_CYC cycles, and for as long as sleep_req stays 1.
- R8: On exit from self refresh, row_strobe_n rises while col_strobe_n stays low for that first cycle, then col_strobe_n rises. mem_ready returns to 1, and bus_req to 0, exactly EXIT_CYC cycles after row_strobe_n rose.
- R9: Self refresh clears the owed count. After wake, no refresh is issued until a full SLOT_CYC interval has passed.
- R10: When the block is idle, a sleep request takes priority over an owed refresh. A sleep request that arrives while a refresh is pending or running waits until that refresh has completed, and mem_ready stays 1 meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Level request for self-refresh standby |
| bus_gnt | input | 1 | Grant of the memory bus from the access controller |
| bus_req | output | 1 | Request for the memory bus, held for the whole refresh or sleep sequence |
| row_strobe_n | output | 1 | Row strobe to the memory, active low |
| col_strobe_n | output | 1 | Column strobe to the memory, active low |
| mem_ready | output | 1 | 1 when the memory is available for accesses (not in self refresh) |

## Verification
Two things can fall in the same cycle: the slot timer expiring and an owed refresh being started from the backlog. The bench forces this by holding the grant back until one refresh is owed. It then raises the grant in the exact cycle before the timer's next expiry, and expects two back-to-back refresh pulses rather than one. A second overlap comes from raising sleep while a refresh is still waiting for the grant. That case is judged by two row-strobe falls, the first of normal length with mem_ready still high. A cycle-level reference model runs alongside both cases and compares all four outputs on every clock.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LEAD,
    ST_ROW,
    ST_PRECH,
    ST_SR_LEAD,
    ST_SR_HOLD,
    ST_SR_EXIT
  } rs_state_e;

  // whole cycles covering a time in ns at a clock in MHz, rounded up
  function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
    return (mhz * ns + 999) / 1000;
  endfunction

  function automatic int unsigned at_least(input int unsigned v, input int unsigned floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  function automatic int unsigned larger(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int unsigned SLOT_CYC = 6250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int TW = $clog2(SLOT_CYC);
  localparam logic [TW-1:0] RELOAD = TW'(SLOT_CYC - 1);

  logic [TW-1:0] remain;

  assign tick = !hold && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       remain <= RELOAD;
    else if (hold || remain == '0)    remain <= RELOAD;
    else                              remain <= remain - 1'b1;
  end
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int unsigned MAX_OWED = 4,
  parameter int OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          issue,
  input  logic          clear,
  output logic [OW-1:0] owed,
  output logic          owed_any
);
  localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

  function automatic logic [OW-1:0] next_owed(input logic [OW-1:0] cur,
                                               input logic add, input logic take);
    if (add && !take)      return (cur == CAP) ? cur : cur + 1'b1;
    else if (take && !add) return cur - 1'b1;
    else                   return cur;
  endfunction

  assign owed_any = (owed != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     owed <= '0;
    else if (clear) owed <= '0;
    else            owed <= next_owed(owed, tick, issue);
  end
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import refresh_pkg::*;
#(
  parameter int unsigned LEAD_CYC  = 2,
  parameter int unsigned ROW_CYC   = 12,
  parameter int unsigned PRE_CYC   = 8,
  parameter int unsigned ENTRY_CYC = 20000,
  parameter int unsigned EXIT_CYC  = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic bus_gnt,
  input  logic owed_any,
  output logic issue,
  output logic accept,
  output logic in_sr,
  output logic row_n,
  output logic col_n,
  output logic bus_req
);
  localparam int unsigned LONGEST =
    larger(larger(larger(LEAD_CYC, ROW_CYC), larger(PRE_CYC, ENTRY_CYC)), EXIT_CYC);
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] LEAD_LAST  = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] ROW_LAST   = CW'(ROW_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST   = CW'(PRE_CYC - 1);
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYC - 1);

  rs_state_e     state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          in_sr_d;
  logic          phase_done;
  logic          exit_first;

  assign phase_done = (cnt == '0);
  assign exit_first = (state == ST_SR_EXIT) && (cnt == EXIT_LAST);

  always_comb begin
    state_d = state;
    cnt_d   = cnt;
    in_sr_d = in_sr;
    issue   = 1'b0;
    accept  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sleep_req) begin
          accept  = 1'b1;
          in_sr_d = 1'b1;
          state_d = ST_WAIT;
        end else if (owed_any) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (bus_gnt) begin
          cnt_d = LEAD_LAST;
          if (in_sr) state_d = ST_SR_LEAD;
          else begin
            state_d = ST_LEAD;
            issue   = 1'b1;
          end
        end
      end
      ST_LEAD: begin
        if (phase_done) begin state_d = ST_ROW; cnt_d = ROW_LAST; end
        else cnt_d = cnt - 1'b1;
      end
      ST_ROW: begin
        if (phase_done) begin state_d = ST_PRECH; cnt_d = PRE_LAST; end
        else cnt_d = cnt - 1'b1;
      end
      ST_PRECH: begin
        if (!phase_done) cnt_d = cnt - 1'b1;
        else if (owed_any) begin
          state_d = ST_LEAD;
          cnt_d   = LEAD_LAST;
          issue   = 1'b1;
        end else state_d = ST_IDLE;
      end
      ST_SR_LEAD: begin
        if (phase_done) begin state_d = ST_SR_HOLD; cnt_d = ENTRY_LAST; end
        else cnt_d = cnt - 1'b1;
      end
      ST_SR_HOLD: begin
        if (!phase_done) cnt_d = cnt - 1'b1;
        else if (!sleep_req) begin state_d = ST_SR_EXIT; cnt_d = EXIT_LAST; end
      end
      ST_SR_EXIT: begin
        if (phase_done) begin state_d = ST_IDLE; in_sr_d = 1'b0; end
        else cnt_d = cnt - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      in_sr <= 1'b0;
    end else begin
      state <= state_d;
      cnt   <= cnt_d;
      in_sr <= in_sr_d;
    end
  end

  assign row_n   = !(state == ST_ROW || state == ST_SR_HOLD);
  assign col_n   = !(state == ST_LEAD || state == ST_ROW || state == ST_SR_LEAD ||
                     state == ST_SR_HOLD || exit_first);
  assign bus_req = (state != ST_IDLE);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned SLOT_NS      = 31250,
  parameter int unsigned CAS_LEAD_NS  = 10,
  parameter int unsigned ROW_LOW_NS   = 60,
  parameter int unsigned PRECHARGE_NS = 40,
  parameter int unsigned SR_ENTRY_NS  = 100000,
  parameter int unsigned SR_EXIT_NS   = 110,
  parameter int unsigned MAX_POSTPONE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic bus_gnt,
  output logic bus_req,
  output logic row_strobe_n,
  output logic col_strobe_n,
  output logic mem_ready
);
  localparam int unsigned SLOT_CYC  = at_least(ns_to_cycles(CLK_MHZ, SLOT_NS), 2);
  localparam int unsigned LEAD_CYC  = at_least(ns_to_cycles(CLK_MHZ, CAS_LEAD_NS), 1);
  localparam int unsigned ROW_CYC   = at_least(ns_to_cycles(CLK_MHZ, ROW_LOW_NS), 1);
  localparam int unsigned PRE_CYC   = at_least(ns_to_cycles(CLK_MHZ, PRECHARGE_NS), 1);
  localparam int unsigned ENTRY_CYC = at_least(ns_to_cycles(CLK_MHZ, SR_ENTRY_NS), 1);
  localparam int unsigned EXIT_CYC  = at_least(ns_to_cycles(CLK_MHZ, SR_EXIT_NS), 2);
  localparam int OWED_W = $clog2(MAX_POSTPONE + 1);

  // named internal events, observed by the bound checker
  logic              slot_tick;
  logic              cbr_issue;
  logic              sr_accept;
  logic              sr_active;
  logic              owed_any;
  logic [OWED_W-1:0] owed_cnt;

  refresh_interval_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (sr_active),
    .tick  (slot_tick)
  );

  refresh_backlog #(.MAX_OWED(MAX_POSTPONE), .OW(OWED_W)) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slot_tick),
    .issue    (cbr_issue),
    .clear    (sr_accept || sr_active),
    .owed     (owed_cnt),
    .owed_any (owed_any)
  );

  refresh_sequencer #(
    .LEAD_CYC  (LEAD_CYC),
    .ROW_CYC   (ROW_CYC),
    .PRE_CYC   (PRE_CYC),
    .ENTRY_CYC (ENTRY_CYC),
    .EXIT_CYC  (EXIT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .bus_gnt   (bus_gnt),
    .owed_any  (owed_any),
    .issue     (cbr_issue),
    .accept    (sr_accept),
    .in_sr     (sr_active),
    .row_n     (row_strobe_n),
    .col_n     (col_strobe_n),
    .bus_req   (bus_req)
  );

  assign mem_ready = !sr_active;
endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
  parameter int unsigned MAX_POSTPONE = 4,
  parameter int unsigned ENTRY_CYC    = 20000,
  parameter int unsigned EXIT_CYC     = 22,
  parameter int OW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          row_n,
  input logic          col_n,
  input logic          bus_req,
  input logic          mem_ready,
  input logic          tick,
  input logic          issue,
  input logic [OW-1:0] owed
);
  logic [31:0] low_run;
  logic [31:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= row_n ? '0 : ((low_run == '1) ? low_run : low_run + 1);
      high_run <= !row_n ? '0 : ((high_run == '1) ? high_run : high_run + 1);
    end
  end

  assert_bus_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_n || !col_n) |-> bus_req);

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_n) |-> (!col_n && $past(!col_n)));

  assert_backlog_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    owed <= OW'(MAX_POSTPONE));

  assert_tick_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && issue) |=> $stable(owed));

  assert_entry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(row_n) && !mem_ready) |-> (low_run >= ENTRY_CYC));

  assert_standby_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> bus_req);

  assert_cas_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(row_n) && !mem_ready) |-> !col_n);

  assert_exit_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (row_n && high_run >= EXIT_CYC));
endmodule

bind refresh_sched refresh_sched_checker #(
  .MAX_POSTPONE (MAX_POSTPONE),
  .ENTRY_CYC    (ENTRY_CYC),
  .EXIT_CYC     (EXIT_CYC),
  .OW           (OWED_W)
) u_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .row_n     (row_strobe_n),
  .col_n     (col_strobe_n),
  .bus_req   (bus_req),
  .mem_ready (mem_ready),
  .tick      (slot_tick),
  .issue     (cbr_issue),
  .owed      (owed_cnt)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
  // timing restated in cycles at 200 MHz for the overrides below
  localparam int T_SLOT = 100, T_LEAD = 2, T_ROW = 8, T_PRE = 6, T_ENTRY = 60, T_EXIT = 20, T_MAX = 3;

  logic clk = 1'b0;
  logic rst_n, sleep_req, bus_gnt;
  logic bus_req, row_strobe_n, col_strobe_n, mem_ready;

  always #2.5 clk = ~clk;

  refresh_sched #(
    .CLK_MHZ(200), .SLOT_NS(500), .CAS_LEAD_NS(10), .ROW_LOW_NS(40),
    .PRECHARGE_NS(30), .SR_ENTRY_NS(300), .SR_EXIT_NS(100), .MAX_POSTPONE(T_MAX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
    .mem_ready(mem_ready)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int M_IDLE = 0, M_WAIT = 1, M_LEAD = 2, M_ROW = 3, M_PRE = 4,
                 M_SLEAD = 5, M_HOLD = 6, M_EXIT = 7;
  int m_ph, m_left, m_tmr, m_pend;
  bit m_sleep;
  int o_ph, o_left, o_pend;
  bit o_sleep, o_tick, o_take, o_acc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = M_IDLE; m_left = 0; m_tmr = T_SLOT - 1; m_pend = 0; m_sleep = 0;
    end else begin
      o_ph = m_ph; o_left = m_left; o_pend = m_pend; o_sleep = m_sleep;
      o_tick = !o_sleep && (m_tmr == 0);
      o_take = 0; o_acc = 0;
      m_tmr = (o_sleep || m_tmr == 0) ? T_SLOT - 1 : m_tmr - 1;
      if (o_ph == M_IDLE) begin
        if (sleep_req) begin o_acc = 1; m_sleep = 1; m_ph = M_WAIT; end
        else if (o_pend > 0) m_ph = M_WAIT;
      end else if (o_ph == M_WAIT) begin
        if (bus_gnt) begin
          m_left = T_LEAD - 1;
          if (o_sleep) m_ph = M_SLEAD; else begin m_ph = M_LEAD; o_take = 1; end
        end
      end else if (o_left > 0 && o_ph != M_HOLD) begin
        m_left = o_left - 1;
      end else begin
        case (o_ph)
          M_LEAD:  begin m_ph = M_ROW; m_left = T_ROW - 1; end
          M_ROW:   begin m_ph = M_PRE; m_left = T_PRE - 1; end
          M_PRE:   if (o_pend > 0) begin m_ph = M_LEAD; m_left = T_LEAD - 1; o_take = 1; end
                   else m_ph = M_IDLE;
          M_SLEAD: begin m_ph = M_HOLD; m_left = T_ENTRY - 1; end
          M_HOLD:  if (o_left > 0) m_left = o_left - 1;
                   else if (!sleep_req) begin m_ph = M_EXIT; m_left = T_EXIT - 1; end
          M_EXIT:  begin m_ph = M_IDLE; m_sleep = 0; end
          default: m_ph = M_IDLE;
        endcase
      end
      if (o_sleep || o_acc) m_pend = 0;
      else begin
        m_pend = o_pend + int'(o_tick) - int'(o_take);
        if (m_pend > T_MAX) m_pend = T_MAX;
      end
    end
  end

  function automatic bit exp_row();
    return !(m_ph == M_ROW || m_ph == M_HOLD);
  endfunction
  function automatic bit exp_col();
    return !(m_ph == M_LEAD || m_ph == M_ROW || m_ph == M_SLEAD || m_ph == M_HOLD ||
             (m_ph == M_EXIT && m_left == T_EXIT - 1));
  endfunction

  // ---------------- stimulus helpers ----------------
  bit gnt_auto = 1;
  bit prev_row = 1;
  int falls = 0;

  task automatic step();
    @(negedge clk);
    chk("R4", "row strobe vs model", int'(row_strobe_n), int'(exp_row()));
    chk("R4", "col strobe vs model", int'(col_strobe_n), int'(exp_col()));
    chk("R3", "bus_req vs model", int'(bus_req), int'(m_ph != M_IDLE));
    chk("R8", "mem_ready vs model", int'(mem_ready), int'(!m_sleep));
    if (prev_row && !row_strobe_n) falls++;
    prev_row = row_strobe_n;
    if (gnt_auto) bus_gnt = bus_req;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int run;
    rst_n = 0; sleep_req = 0; bus_gnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "row strobe in reset", int'(row_strobe_n), 1);
    chk("R1", "col strobe in reset", int'(col_strobe_n), 1);
    chk("R1", "bus_req in reset", int'(bus_req), 0);
    chk("R1", "mem_ready in reset", int'(mem_ready), 1);
    rst_n = 1;

    // R2: one refresh per slot with prompt grant
    falls = 0;
    steps(350);
    chk("R2", "refreshes in 350 cycles", falls, 3);

    // R3 / R5: grant withheld, backlog saturates, then drained back to back
    gnt_auto = 0; bus_gnt = 0;
    falls = 0;
    steps(520);
    chk("R3", "pulses without grant", falls, 0);
    chk("R3", "bus_req held waiting", int'(bus_req), 1);
    for (int i = 0; i < 200 && m_tmr != T_SLOT - 3; i++) step();
    bus_gnt = 1;
    falls = 0;
    for (int i = 0; i < 300 && bus_req; i++) step();
    chk("R5", "back-to-back pulses after saturation", falls, T_MAX);
    bus_gnt = 0;

    // R6: slot expiry in the same cycle as a started refresh
    for (int i = 0; i < 300 && !(m_pend == 1 && bus_req); i++) step();
    for (int i = 0; i < 200 && m_tmr != 0; i++) step();
    bus_gnt = 1;
    falls = 0;
    for (int i = 0; i < 300 && bus_req; i++) step();
    chk("R6", "pulses when tick meets issue", falls, 2);
    bus_gnt = 0; gnt_auto = 1;

    // R7 / R8 / R9: long sleep
    for (int i = 0; i < 300 && (bus_req || m_pend != 0); i++) step();
    sleep_req = 1;
    step();
    chk("R7", "mem_ready after accept", int'(mem_ready), 0);
    falls = 0;
    steps(150);
    chk("R7", "row held low in sleep", int'(row_strobe_n), 0);
    chk("R7", "single entry pulse", falls, 1);
    sleep_req = 0;
    for (int i = 0; i < 100 && !row_strobe_n; i++) step();
    chk("R8", "col still low as row rises", int'(col_strobe_n), 0);
    run = 0;
    for (int i = 0; i < 100 && !mem_ready; i++) begin
      step();
      run++;
      if (run == 1) chk("R8", "col high after row", int'(col_strobe_n), 1);
    end
    chk("R8", "cycles until ready", run, T_EXIT);
    chk("R8", "bus_req released on wake", int'(bus_req), 0);
    gnt_auto = 0; bus_gnt = 1;   // grant held high while idle must do nothing
    falls = 0;
    steps(95);
    chk("R9", "no burst after wake (R3 idle grant)", falls, 0);
    steps(20);
    chk("R9", "slot refresh after full interval", falls, 1);
    gnt_auto = 1;

    // R7: one-cycle sleep pulse still holds minimum entry time
    for (int i = 0; i < 300 && (bus_req || m_pend != 0); i++) step();
    sleep_req = 1;
    step();
    sleep_req = 0;
    for (int i = 0; i < 100 && row_strobe_n; i++) step();
    run = 0;
    for (int i = 0; i < 200 && !row_strobe_n; i++) begin run++; step(); end
    chk("R7", "minimum low time in self refresh", run, T_ENTRY);
    for (int i = 0; i < 100 && !mem_ready; i++) step();

    // R10: sleep arriving while a refresh waits for grant
    gnt_auto = 0; bus_gnt = 0;
    for (int i = 0; i < 300 && !(m_pend == 1 && bus_req); i++) step();
    sleep_req = 1; bus_gnt = 1;
    falls = 0;
    steps(10);
    chk("R10", "ready kept during pending refresh", int'(mem_ready), 1);
    steps(30);
    chk("R10", "refresh then sleep entry", falls, 2);
    chk("R10", "in standby after refresh", int'(mem_ready), 0);
    sleep_req = 0;
    for (int i = 0; i < 200 && !mem_ready; i++) step();
    chk("R10", "woke after sequence", int'(mem_ready), 1);
    steps(5);

    summary();
    $finish;
  end
endmodule